// File: doc/BRIEF.md
# Waterfall Line Decimator

This block takes a stream of spectrum frames and turns them into a slower stream of waterfall display lines. Each input item is 32 bits wide and carries a bin's log-power magnitude in its upper 16 bits. A frame is a run of items closed by `tlast`, and its length is a power of two from 16 to 128. Each bin keeps its own per-bin state. Over a group of frames, that state either follows the peak or adds up the magnitudes.

When the last frame of a group has been taken in, the block sends one line. The line holds one byte per bin, with four bins packed into each 32-bit output item. It then clears the per-bin state and starts the next group. The group length, the combining mode and the scaling of summed values come from static configuration inputs. An enable and a clear let the surrounding logic flush the block at any time.

Top module: `wfd_waterfall_decim`

## Requirements
- R1: One line is sent for every (D + 2) complete input frames, where D is the unsigned 8-bit value on `cfg_decim`. Frames left over after the last sent line produce no output.
- R2: For an N-bin frame, a line is N/4 output items. `m_tlast` is high on the final item only. Bin 4k+j sits in bits 8j+7:8j of item k, so bin 0 occupies bits 7:0 of the first item.
- R3: With `cfg_ctrl[7]` = 0 (peak mode), each output byte is the largest value of input bits 31:24 seen for that bin across the group. Input bits 23:0 do not affect it.
- R4: With `cfg_ctrl[7]` = 1 (sum mode), each output byte is the group sum of input bits 31:16 for that bin. The sum is shifted right by 0, 3, 6 or 8 places for `cfg_ctrl[1:0]` = 0, 1, 2, 3, and the result saturates at 255.
- R5: Bits 6:2 of `cfg_ctrl` have no effect on any output.
- R6: While `cfg_enable` is low, `m_tvalid` is low and `s_tready` is high. Input beats are taken and thrown away, and the frame count and per-bin state are emptied, so nothing seen while disabled reaches a later line.
- R7: A cycle with `cfg_clear` high empties the frame count and per-bin state and drops any partial group and any line still being sent.
- R8: While a line is being sent, `s_tready` is low. A stalled output item keeps its data until it is accepted.
- R9: Once a line has been sent, the next group starts from empty state in both modes.
- R10: After reset, `m_tvalid` is low and `s_tready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Block enable; low flushes and discards input |
| cfg_clear | input | 1 | One-cycle flush of the group and any line in flight |
| cfg_ctrl | input | 8 | Bit 7 selects the combining mode; bits 1:0 select the sum shift |
| cfg_decim | input | 8 | Group length minus two, in frames |
| s_tdata | input | 32 | Input item; bits 31:16 are the magnitude |
| s_tvalid | input | 1 | Input item valid |
| s_tlast | input | 1 | Last item of a frame |
| s_tready | output | 1 | Input item accepted |
| m_tdata | output | 32 | Four packed line bytes |
| m_tvalid | output | 1 | Output item valid |
| m_tlast | output | 1 | Last item of a line |
| m_tready | input | 1 | Downstream accepts the output item |

## Verification
The bench targets several corner cases. Group lengths of two and five frames must fire on the right frame. A design that miscounts by one would emit lines one frame early or late and fail the line counts. In sum mode, sums of 512 and of 0x8000 shifted by 8 must give 0xFF and 0x80: a missing saturation would wrap the first to 0x00, and a wrong shift would break the second. In peak mode, small low-order bits must not win, and a line must start fresh after the previous one. A design that kept the old peak would emit 0x34 bytes where 0x06 is expected. Frames sent while disabled and a frame sent just before a clear must leave no trace in the next line. Random output stalls check that input is held off and that data stays put during a line.

// File: rtl/wfd_pkg.sv
package wfd_pkg;

  // How successive frames fold into one line
  typedef enum logic {
    WFD_PEAK = 1'b0,
    WFD_SUM  = 1'b1
  } wfd_combine_e;

  // Position of fields inside the control byte
  localparam int CTRL_MODE_BIT = 7;

  // Right shift applied to a summed bin for each scale select
  function automatic logic [3:0] scale_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  // Reduce one bin's stored value to its display byte
  function automatic logic [7:0] bin_to_byte(input logic [31:0] acc,
                                             input wfd_combine_e mode,
                                             input logic [1:0] sel);
    logic [31:0] scaled;
    if (mode == WFD_PEAK) begin
      return acc[7:0];
    end
    scaled = acc >> scale_shift(sel);
    if (scaled > 32'd255) begin
      return 8'hFF;
    end
    return scaled[7:0];
  endfunction

endpackage

// File: rtl/wfd_frame_tracker.sv
module wfd_frame_tracker #(
  parameter int MAX_BINS = 128,
  parameter int DECIM_W  = 8,
  parameter int LANES    = 4,
  localparam int IDX_W      = $clog2(MAX_BINS),
  localparam int ITEM_IDX_W = $clog2(MAX_BINS / LANES),
  localparam int CNT_W      = DECIM_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  beat,
  input  logic                  beat_last,
  input  logic [DECIM_W-1:0]    decim,
  output logic [IDX_W-1:0]      bin_idx,
  output logic                  line_go,
  output logic [ITEM_IDX_W-1:0] last_item
);

  logic [CNT_W-1:0] frame_cnt;
  logic [CNT_W-1:0] target_m1;
  logic [IDX_W:0]   frame_len;
  logic [IDX_W:0]   items_n;
  logic [IDX_W:0]   items_m1;

  // Frames per group is decim + 2; the group closes on frame index decim + 1
  assign target_m1 = CNT_W'(decim) + CNT_W'(1);
  assign line_go   = beat & beat_last & (frame_cnt == target_m1);

  // Length of the frame that is closing, in bins and in packed items
  assign frame_len = {1'b0, bin_idx} + (IDX_W + 1)'(1);
  assign items_n   = frame_len >> $clog2(LANES);
  assign items_m1  = items_n - (IDX_W + 1)'(1);
  assign last_item = items_m1[ITEM_IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      frame_cnt <= '0;
      bin_idx   <= '0;
    end else if (beat) begin
      if (beat_last) begin
        bin_idx   <= '0;
        frame_cnt <= line_go ? '0 : frame_cnt + CNT_W'(1);
      end else if (bin_idx != IDX_W'(MAX_BINS - 1)) begin
        bin_idx <= bin_idx + IDX_W'(1);
      end
    end
  end

  // R1
  group_restart_chk: assert property (@(posedge clk) disable iff (rst)
    line_go && !flush |=> frame_cnt == '0);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> frame_cnt == '0 && bin_idx == '0);

endmodule

// File: rtl/wfd_bin_store.sv
module wfd_bin_store #(
  parameter int MAX_BINS = 128,
  parameter int MAG_W    = 16,
  parameter int ACC_W    = 25,
  parameter int LANES    = 4,
  localparam int IDX_W      = $clog2(MAX_BINS),
  localparam int ITEM_IDX_W = $clog2(MAX_BINS / LANES),
  localparam int LANE_W     = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [MAG_W-1:0]       wr_mag,
  input  logic                   mode_sum,
  input  logic [ITEM_IDX_W-1:0]  rd_item,
  input  logic                   release_en,
  output logic [LANES*ACC_W-1:0] rd_acc
);

  logic [ACC_W-1:0] acc [MAX_BINS];
  logic [7:0]       peak_byte;
  logic             any_held;

  assign peak_byte = wr_mag[MAG_W-1 -: 8];

  for (genvar b = 0; b < MAX_BINS; b++) begin : g_bin
    logic hit;
    logic freed;
    assign hit   = wr_en && (wr_idx == IDX_W'(b));
    assign freed = release_en && (rd_item == ITEM_IDX_W'(b / LANES));
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        acc[b] <= '0;
      end else if (hit) begin
        if (mode_sum) begin
          acc[b] <= acc[b] + ACC_W'(wr_mag);
        end else if (ACC_W'(peak_byte) > acc[b]) begin
          acc[b] <= ACC_W'(peak_byte);
        end
      end else if (freed) begin
        acc[b] <= '0;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_acc[l*ACC_W +: ACC_W] = acc[{rd_item, LANE_W'(l)}];
  end

  always_comb begin
    any_held = 1'b0;
    for (int b = 0; b < MAX_BINS; b++) begin
      any_held = any_held | (|acc[b]);
    end
  end

  // R6
  store_flushed_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_held);

endmodule

// File: rtl/wfd_line_packer.sv
module wfd_line_packer #(
  parameter int ACC_W      = 25,
  parameter int LANES      = 4,
  parameter int ITEM_IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   start,
  input  logic [ITEM_IDX_W-1:0]  start_last,
  input  logic                   mode_sum,
  input  logic [1:0]             scale_sel,
  input  logic [LANES*ACC_W-1:0] rd_acc,
  input  logic                   out_ready,
  output logic                   emitting,
  output logic [ITEM_IDX_W-1:0]  item_idx,
  output logic                   item_done,
  output logic [LANES*8-1:0]     out_data,
  output logic                   out_last
);
  import wfd_pkg::*;

  logic [ITEM_IDX_W-1:0] last_idx;
  wfd_combine_e          mode;

  assign mode      = wfd_combine_e'(mode_sum);
  assign item_done = emitting & out_ready;
  assign out_last  = emitting & (item_idx == last_idx);

  for (genvar l = 0; l < LANES; l++) begin : g_byte
    assign out_data[l*8 +: 8] =
      bin_to_byte(32'(rd_acc[l*ACC_W +: ACC_W]), mode, scale_sel);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      emitting <= 1'b0;
      item_idx <= '0;
      last_idx <= '0;
    end else if (!emitting) begin
      if (start) begin
        emitting <= 1'b1;
        item_idx <= '0;
        last_idx <= start_last;
      end
    end else if (item_done) begin
      if (item_idx == last_idx) begin
        emitting <= 1'b0;
      end else begin
        item_idx <= item_idx + ITEM_IDX_W'(1);
      end
    end
  end

  // R8
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst || flush)
    emitting && !out_ready |=> emitting && $stable(out_data) && $stable(item_idx));

  // R2
  line_closes_chk: assert property (@(posedge clk) disable iff (rst || flush)
    item_done && out_last |=> !emitting);

endmodule

// File: rtl/wfd_waterfall_decim.sv
module wfd_waterfall_decim #(
  parameter int MAX_BINS = 128,
  parameter int MAG_W    = 16,
  parameter int DECIM_W  = 8,
  parameter int LANES    = 4,
  localparam int ITEM_W     = LANES * 8,
  localparam int IDX_W      = $clog2(MAX_BINS),
  localparam int ITEM_IDX_W = $clog2(MAX_BINS / LANES),
  localparam int ACC_W      = MAG_W + $clog2((1 << DECIM_W) + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_clear,
  input  logic [7:0]        cfg_ctrl,
  input  logic [DECIM_W-1:0] cfg_decim,
  input  logic [ITEM_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [ITEM_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready
);
  import wfd_pkg::*;

  logic                   flush;
  logic                   beat;
  logic                   mode_sum;
  logic                   emitting;
  logic                   line_go;
  logic                   item_done;
  logic                   pk_last;
  logic [IDX_W-1:0]       bin_idx;
  logic [ITEM_IDX_W-1:0]  last_item;
  logic [ITEM_IDX_W-1:0]  item_idx;
  logic [LANES*ACC_W-1:0] rd_acc;

  assign flush    = cfg_clear | ~cfg_enable;
  assign mode_sum = cfg_ctrl[CTRL_MODE_BIT];
  assign s_tready = ~emitting | ~cfg_enable;
  assign beat     = s_tvalid & s_tready & ~flush;
  assign m_tvalid = emitting & cfg_enable;
  assign m_tlast  = pk_last & cfg_enable;

  wfd_frame_tracker #(
    .MAX_BINS (MAX_BINS),
    .DECIM_W  (DECIM_W),
    .LANES    (LANES)
  ) tracker_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .beat      (beat),
    .beat_last (s_tlast),
    .decim     (cfg_decim),
    .bin_idx   (bin_idx),
    .line_go   (line_go),
    .last_item (last_item)
  );

  wfd_bin_store #(
    .MAX_BINS (MAX_BINS),
    .MAG_W    (MAG_W),
    .ACC_W    (ACC_W),
    .LANES    (LANES)
  ) store_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_en      (beat),
    .wr_idx     (bin_idx),
    .wr_mag     (s_tdata[ITEM_W-1 -: MAG_W]),
    .mode_sum   (mode_sum),
    .rd_item    (item_idx),
    .release_en (item_done & ~flush),
    .rd_acc     (rd_acc)
  );

  wfd_line_packer #(
    .ACC_W      (ACC_W),
    .LANES      (LANES),
    .ITEM_IDX_W (ITEM_IDX_W)
  ) packer_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .start      (line_go),
    .start_last (last_item),
    .mode_sum   (mode_sum),
    .scale_sel  (cfg_ctrl[1:0]),
    .rd_acc     (rd_acc),
    .out_ready  (m_tready),
    .emitting   (emitting),
    .item_idx   (item_idx),
    .item_done  (item_done),
    .out_data   (m_tdata),
    .out_last   (pk_last)
  );

  // R8
  input_blocked_chk: assert property (@(posedge clk) disable iff (rst || flush)
    line_go |=> !s_tready && m_tvalid);

  // R6
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> !m_tvalid && s_tready);

endmodule

// File: tb/wfd_waterfall_decim_tb_top.sv
module wfd_waterfall_decim_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic        cfg_clear = 1'b0;
  logic [7:0]  cfg_ctrl = 8'h00;
  logic [7:0]  cfg_decim = 8'h00;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b1;
  bit          stall_on = 1'b0;

  int checks = 0;
  int errors = 0;
  int lines = 0;
  int items_now = 0;
  int last_len = 0;
  logic [31:0] first_word = '0;

  // Behavioural reference state
  int          ref_bin [128];
  int          ref_frames = 0;
  int          ref_pos = 0;
  int          ref_len = 0;
  logic [32:0] ref_out [$];

  always #2 clk = ~clk;

  wfd_waterfall_decim dut_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .cfg_clear  (cfg_clear),
    .cfg_ctrl   (cfg_ctrl),
    .cfg_decim  (cfg_decim),
    .s_tdata    (s_tdata),
    .s_tvalid   (s_tvalid),
    .s_tlast    (s_tlast),
    .s_tready   (s_tready),
    .m_tdata    (m_tdata),
    .m_tvalid   (m_tvalid),
    .m_tlast    (m_tlast),
    .m_tready   (m_tready)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Display byte of one bin, from R3 / R4 / R5 (only bits 7 and 1:0 matter)
  function automatic logic [7:0] ref_byte(input int v);
    int div;
    if (cfg_ctrl[7] == 1'b0) return v[7:0];
    div = (cfg_ctrl[1:0] == 2'd0) ? 1 : (cfg_ctrl[1:0] == 2'd1) ? 8 :
          (cfg_ctrl[1:0] == 2'd2) ? 64 : 256;
    v = v / div;
    return (v > 255) ? 8'hFF : v[7:0];
  endfunction

  always @(posedge clk) begin : ref_model
    int mag;
    if (rst || !cfg_enable || cfg_clear) begin
      foreach (ref_bin[i]) ref_bin[i] = 0;
      ref_frames = 0;
      ref_pos = 0;
      ref_out.delete();
    end else if (ref_out.size() != 0) begin
      if (m_tready) void'(ref_out.pop_front());
    end else if (s_tvalid) begin
      mag = s_tdata[31:16];
      if (cfg_ctrl[7]) ref_bin[ref_pos] += mag;
      else if (int'(s_tdata[31:24]) > ref_bin[ref_pos]) ref_bin[ref_pos] = s_tdata[31:24];
      if (s_tlast) begin
        ref_len = ref_pos + 1;
        ref_pos = 0;
        ref_frames++;
        if (ref_frames == int'(cfg_decim) + 2) begin
          for (int k = 0; k < ref_len / 4; k++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) w[8*j +: 8] = ref_byte(ref_bin[4*k + j]);
            ref_out.push_back({(k == ref_len / 4 - 1), w});
          end
          foreach (ref_bin[i]) ref_bin[i] = 0;
          ref_frames = 0;
        end
      end else begin
        ref_pos++;
      end
    end
  end

  always @(negedge clk) begin : compare
    bit exp_valid;
    bit exp_ready;
    if (!rst) begin
      exp_valid = cfg_enable && ref_out.size() != 0;
      exp_ready = !cfg_enable || ref_out.size() == 0;
      check(m_tvalid == exp_valid, "R1 valid", 64'(m_tvalid), 64'(exp_valid));
      check(s_tready == exp_ready, "R8 ready", 64'(s_tready), 64'(exp_ready));
      if (exp_valid && m_tvalid) begin
        check(m_tdata == ref_out[0][31:0], cfg_ctrl[7] ? "R4 data" : "R3 data",
              64'(m_tdata), 64'(ref_out[0][31:0]));
        check(m_tlast == ref_out[0][32], "R2 last", 64'(m_tlast), 64'(ref_out[0][32]));
      end
      if (m_tvalid && m_tready) begin
        if (items_now == 0) first_word = m_tdata;
        items_now++;
        if (m_tlast) begin
          lines++;
          last_len = items_now;
          items_now = 0;
        end
      end
    end
  end

  initial begin : ready_driver
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      m_tready = stall_on ? ((cyc % 3) != 1) : 1'b1;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic send_frame(input int len, input int seed, input bit konst,
                            input logic [15:0] kmag);
    for (int i = 0; i < len; i++) begin
      bit ok;
      s_tvalid = 1'b1;
      s_tlast = (i == len - 1);
      if (konst) s_tdata = {kmag, 16'(i * 7 + 3)};
      else s_tdata = 32'((seed * 40503 + i * 9973) ^ (i << 21) ^ (seed << 27));
      do begin
        @(negedge clk);
        ok = s_tready;
        @(posedge clk);
        #1;
      end while (!ok);
    end
    s_tvalid = 1'b0;
    s_tlast = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_tvalid || !s_tready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    cfg_clear = 1'b1;
    @(posedge clk);
    #1;
    cfg_clear = 1'b0;
  endtask

  initial begin : stimulus
    int base;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check(m_tvalid == 1'b0, "R10 valid", 64'(m_tvalid), 64'd0);
    check(s_tready == 1'b1, "R10 ready", 64'(s_tready), 64'd1);
    @(posedge clk);
    #1;
    cfg_enable = 1'b1;

    // R1, R3: peak mode, group of two frames
    cfg_ctrl = 8'h00; cfg_decim = 8'd0; base = lines;
    for (int f = 0; f < 6; f++) send_frame(16, f + 1, 1'b0, 16'h0);
    wait_idle();
    check(lines - base == 3, "R1 lines d0", 64'(lines - base), 64'd3);

    // R1, R2, R4: sum mode /8, group of five, stalled output
    stall_on = 1'b1;
    cfg_ctrl = 8'h81; cfg_decim = 8'd3; base = lines;
    for (int f = 0; f < 11; f++) send_frame(32, f + 20, 1'b0, 16'h0);
    wait_idle();
    check(lines - base == 2, "R1 lines d3", 64'(lines - base), 64'd2);
    check(last_len == 8, "R2 len32", 64'(last_len), 64'd8);
    pulse_clear();

    // R5, R2: junk in control bits 6:2, longest frame
    cfg_ctrl = 8'hFF; cfg_decim = 8'd1; base = lines;
    for (int f = 0; f < 3; f++) send_frame(128, f + 40, 1'b0, 16'h0);
    wait_idle();
    check(lines - base == 1, "R5 lines", 64'(lines - base), 64'd1);
    check(last_len == 32, "R2 len128", 64'(last_len), 64'd32);
    pulse_clear();
    stall_on = 1'b0;

    // R4: saturation with no shift, then shift by 8
    cfg_ctrl = 8'h80; cfg_decim = 8'd0;
    send_frame(16, 0, 1'b1, 16'h0100);
    send_frame(16, 0, 1'b1, 16'h0100);
    wait_idle();
    check(first_word == 32'hFFFFFFFF, "R4 saturate", 64'(first_word), 64'hFFFFFFFF);
    cfg_ctrl = 8'h83;
    send_frame(16, 0, 1'b1, 16'h4000);
    send_frame(16, 0, 1'b1, 16'h4000);
    wait_idle();
    check(first_word == 32'h80808080, "R4 shift8", 64'(first_word), 64'h80808080);

    // R3, R9: peak ignores low bits, then restarts after a line
    cfg_ctrl = 8'h00;
    send_frame(16, 0, 1'b1, 16'h12FF);
    send_frame(16, 0, 1'b1, 16'h3400);
    wait_idle();
    check(first_word == 32'h34343434, "R3 peak", 64'(first_word), 64'h34343434);
    send_frame(16, 0, 1'b1, 16'h0500);
    send_frame(16, 0, 1'b1, 16'h0600);
    wait_idle();
    check(first_word == 32'h06060606, "R9 fresh", 64'(first_word), 64'h06060606);

    // R6: disabled input is dropped
    cfg_enable = 1'b0; base = lines;
    for (int f = 0; f < 4; f++) send_frame(16, 0, 1'b1, 16'h7F00);
    wait_idle();
    check(lines == base, "R6 silent", 64'(lines), 64'(base));
    cfg_enable = 1'b1;
    send_frame(16, 0, 1'b1, 16'h0700);
    send_frame(16, 0, 1'b1, 16'h0700);
    wait_idle();
    check(first_word == 32'h07070707, "R6 no trace", 64'(first_word), 64'h07070707);

    // R7: clear drops a partial group
    send_frame(16, 0, 1'b1, 16'h7700);
    pulse_clear();
    send_frame(16, 0, 1'b1, 16'h0100);
    send_frame(16, 0, 1'b1, 16'h0200);
    wait_idle();
    check(first_word == 32'h02020202, "R7 clear", 64'(first_word), 64'h02020202);

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule